// File: doc/BRIEF.md
# Hash-Indexed Set-Associative Flow Cache

This block remembers the classification results of recently seen network flows so that later packets of the same flow can skip the full classifier. Storage is split into several independent ways. Each way is a direct-mapped table addressed by a hash index that the caller computes beforehand. A lookup presents a flow identifier and its index. One clock later the block answers hit or miss, and on a hit it also returns the stored result. After a miss, the classifier sends the new flow and its result in through the insert port.

An insert can fill an empty way freely, but evicting a resident flow is allowed only with a probability equal to the block's running hit-ratio estimate. While the cache is serving most lookups, it admits new flows readily. While it misses a lot, which usually means a burst of short-lived flows, it keeps its current residents. The random draw comes from a free-running LFSR. The victim is chosen by per-set recency bits. A synchronous clear empties the cache and zeroes the estimate.

Top module: `flowc_cache`

## Requirements
- R1: A lookup accepted in cycle t (`lk_valid`=1, `clr`=0) raises `rsp_valid` in cycle t+1. `rsp_hit` is 1 exactly when some valid way at `lk_index` holds `lk_flow`. On a hit, `rsp_class` is that way's result; on a miss it is 0. With no accepted lookup, `rsp_valid` is 0.
- R2: An insert whose flow is already valid in some way of the indexed set overwrites that way's result, whatever the hit ratio. No other way changes.
- R3: An insert of a flow not in the set, while the set has an invalid way, always writes the lowest-numbered invalid way.
- R4: An insert of a flow not in the set, while all ways are valid, evicts the victim only when the LFSR value is below h (unsigned). Otherwise it is dropped and the set is unchanged.
- R5: Each set keeps one recency bit per way. A write by an insert, and a lookup hit, each touch their way: the way's bit is set, and if all bits would then be 1, only the touched bit stays set. When an insert and a lookup hit touch the same set in one cycle, the insert is applied first. The victim is the lowest-numbered way whose bit is 0.
- R6: h is a 16-bit fraction. Each accepted lookup replaces it with h - (h>>4) - (h>>5) + (h>>7), plus 6554 on a hit, saturating at 65535. Admission uses the value held before that cycle's update.
- R7: The LFSR loads 0xACE1 in reset. Every cycle afterwards, it shifts left with new bit 0 = bit15 ^ bit13 ^ bit12 ^ bit10. A clear does not affect it.
- R8: A lookup and an insert at the same index in the same cycle are ordered insert first, so the lookup sees the entry just written.
- R9: A cycle with `clr`=1 invalidates every entry, zeroes h and all recency bits, and ignores any lookup or insert in that cycle (no `rsp_valid` follows).
- R10: After reset every entry is invalid, h is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous cache clear |
| lk_valid | input | 1 | Lookup request |
| lk_flow | input | ID_W | Flow identifier to look up |
| lk_index | input | IDX_W | Precomputed hash index of the lookup |
| ins_valid | input | 1 | Insert request |
| ins_flow | input | ID_W | Flow identifier to insert |
| ins_index | input | IDX_W | Hash index of the insert |
| ins_class | input | RES_W | Classification result to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup found the flow |
| rsp_class | output | RES_W | Result of the hit, 0 on a miss |

## Verification
Most internal faults in this block show up only later, through admission decisions. A wrong hit-ratio value or LFSR step changes whether a later insert into a full set evicts anything, and a wrong recency bit changes which flow is evicted. Either shows at the ports as a hit or miss that differs from the expected one on the next lookup of the affected flows. That lookup may come many cycles after the fault. The bench therefore runs a cycle-accurate reference of the stated rules alongside the design and compares every response, so a divergence is reported on the first lookup that can reveal it. Bypass and overwrite faults show up in the very next response.

// File: rtl/flowc_pkg.sv
package flowc_pkg;

    localparam int unsigned RATIO_W = 16;

    typedef logic [RATIO_W-1:0] ratio_t;

    // About 0.914 * h using shifts only; never underflows.
    function automatic ratio_t ratio_decay(input ratio_t h);
        return h - (h >> 4) - (h >> 5) + (h >> 7);
    endfunction

    // Maximal-length 16-bit Fibonacci step, taps 16/14/13/11.
    function automatic ratio_t lfsr_next(input ratio_t s);
        return {s[RATIO_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/flowc_way.sv
module flowc_way #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned ID_W  = 32,
    parameter int unsigned RES_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [ID_W-1:0]  w_id,
    input  logic [RES_W-1:0] w_res,
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [ID_W-1:0]  a_id,
    output logic [RES_W-1:0] a_res,
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [ID_W-1:0]  b_id
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [ID_W-1:0]  id_q  [DEPTH];
    logic [RES_W-1:0] res_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            valid_q <= '0;
        end else if (we) begin
            valid_q[w_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !clr) begin
            id_q[w_idx]  <= w_id;
            res_q[w_idx] <= w_res;
        end
    end

    always_comb begin
        a_valid = valid_q[a_idx];
        a_id    = id_q[a_idx];
        a_res   = res_q[a_idx];
        b_valid = valid_q[b_idx];
        b_id    = id_q[b_idx];
    end

    // R3: a written entry is valid afterwards
    assert_write_sets_valid_R3: assert property (@(posedge clk) disable iff (rst)
        (we && !clr) |=> valid_q[$past(w_idx)]);

    // R9: a clear leaves nothing valid
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (valid_q == '0));

endmodule

// File: rtl/flowc_recency.sv
module flowc_recency #(
    parameter int unsigned NWAYS = 4,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             t0_en,
    input  logic [IDX_W-1:0] t0_idx,
    input  logic [NWAYS-1:0] t0_way,
    input  logic             t1_en,
    input  logic [IDX_W-1:0] t1_idx,
    input  logic [NWAYS-1:0] t1_way,
    input  logic [IDX_W-1:0] q_idx,
    output logic [NWAYS-1:0] victim
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [NWAYS-1:0] mru_q [DEPTH];
    logic [NWAYS-1:0] mru_d [DEPTH];

    function automatic logic [NWAYS-1:0] touch(input logic [NWAYS-1:0] b,
                                               input logic [NWAYS-1:0] oh);
        logic [NWAYS-1:0] t;
        t = b | oh;
        return (&t) ? oh : t;
    endfunction

    function automatic logic [NWAYS-1:0] first_one(input logic [NWAYS-1:0] v);
        logic [NWAYS-1:0] r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            mru_d[s] = mru_q[s];
            if (t0_en && t0_idx == IDX_W'(s)) mru_d[s] = touch(mru_d[s], t0_way);
            if (t1_en && t1_idx == IDX_W'(s)) mru_d[s] = touch(mru_d[s], t1_way);
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (rst || clr) mru_q[s] <= '0;
            else            mru_q[s] <= mru_d[s];
        end
    end

    assign victim = first_one(~mru_q[q_idx]);

    // R5: a set never has every recency bit set, so a victim exists
    assert_never_saturated_R5: assert property (@(posedge clk) disable iff (rst)
        !(&mru_q[q_idx]));

    // R5: exactly one victim way is offered
    assert_victim_single_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(victim) == 1);

endmodule

// File: rtl/flowc_ratio.sv
module flowc_ratio
    import flowc_pkg::*;
#(
    parameter ratio_t HIT_GAIN  = 16'd6554,
    parameter ratio_t LFSR_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic upd,
    input  logic hit,
    output logic admit
);
    ratio_t           h_q;
    ratio_t           lfsr_q;
    ratio_t           h_nxt;
    logic [RATIO_W:0] sum;

    always_comb begin
        sum   = {1'b0, ratio_decay(h_q)} + (hit ? {1'b0, HIT_GAIN} : '0);
        h_nxt = sum[RATIO_W] ? '1 : sum[RATIO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q    <= '0;
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= lfsr_next(lfsr_q);
            if (clr)      h_q <= '0;
            else if (upd) h_q <= h_nxt;
        end
    end

    assign admit = lfsr_q < h_q;

    // R7: the generator never locks up in the all-zero state
    assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    // R6: a miss never raises the estimate
    assert_miss_decays_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && !hit && !clr) |=> (h_q <= $past(h_q)));

    // R6: a hit raises the estimate unless it is saturated
    assert_hit_rises_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && hit && !clr && (h_q != '1)) |=> (h_q > $past(h_q)));

    // R9: clear zeroes the estimate
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (h_q == '0));

endmodule

// File: rtl/flowc_cache.sv
module flowc_cache #(
    parameter int unsigned NWAYS = 4,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned ID_W  = 32,
    parameter int unsigned RES_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             lk_valid,
    input  logic [ID_W-1:0]  lk_flow,
    input  logic [IDX_W-1:0] lk_index,
    input  logic             ins_valid,
    input  logic [ID_W-1:0]  ins_flow,
    input  logic [IDX_W-1:0] ins_index,
    input  logic [RES_W-1:0] ins_class,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [RES_W-1:0] rsp_class
);
    logic [NWAYS-1:0] look_valid;
    logic [ID_W-1:0]  look_id  [NWAYS];
    logic [RES_W-1:0] look_res [NWAYS];
    logic [NWAYS-1:0] probe_valid;
    logic [ID_W-1:0]  probe_id [NWAYS];

    logic [NWAYS-1:0] ins_match;
    logic [NWAYS-1:0] ins_sel;
    logic [NWAYS-1:0] ins_we;
    logic [NWAYS-1:0] victim;
    logic             admit;
    logic             ins_go;
    logic             lk_go;
    logic             same_set;

    logic [NWAYS-1:0] ov_valid;
    logic [ID_W-1:0]  ov_id  [NWAYS];
    logic [RES_W-1:0] ov_res [NWAYS];
    logic [NWAYS-1:0] hit_vec;
    logic [NWAYS-1:0] hit_oh;
    logic [RES_W-1:0] hit_res;

    logic             rsp_valid_q;
    logic             rsp_hit_q;
    logic [RES_W-1:0] rsp_class_q;

    function automatic logic [NWAYS-1:0] first_one(input logic [NWAYS-1:0] v);
        logic [NWAYS-1:0] r;
        r = '0;
        for (int i = NWAYS - 1; i >= 0; i--) begin
            if (v[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    assign ins_go   = ins_valid && !clr;
    assign lk_go    = lk_valid && !clr;
    assign same_set = (ins_index == lk_index);

    generate
        for (genvar w = 0; w < NWAYS; w++) begin : g_way
            flowc_way #(
                .IDX_W (IDX_W),
                .ID_W  (ID_W),
                .RES_W (RES_W)
            ) u_way (
                .clk     (clk),
                .rst     (rst),
                .clr     (clr),
                .we      (ins_we[w]),
                .w_idx   (ins_index),
                .w_id    (ins_flow),
                .w_res   (ins_class),
                .a_idx   (lk_index),
                .a_valid (look_valid[w]),
                .a_id    (look_id[w]),
                .a_res   (look_res[w]),
                .b_idx   (ins_index),
                .b_valid (probe_valid[w]),
                .b_id    (probe_id[w])
            );

            assign ins_match[w] = probe_valid[w] && (probe_id[w] == ins_flow);

            // Insert-first view of the lookup set
            assign ov_valid[w] = (ins_we[w] && same_set) || look_valid[w];
            assign ov_id[w]    = (ins_we[w] && same_set) ? ins_flow  : look_id[w];
            assign ov_res[w]   = (ins_we[w] && same_set) ? ins_class : look_res[w];
            assign hit_vec[w]  = ov_valid[w] && (ov_id[w] == lk_flow);
        end
    endgenerate

    // Way selection for an insert: resident flow, then free way, then victim
    always_comb begin
        if (|ins_match)         ins_sel = first_one(ins_match);
        else if (~&probe_valid) ins_sel = first_one(~probe_valid);
        else if (admit)         ins_sel = victim;
        else                    ins_sel = '0;
        ins_we = ins_go ? ins_sel : '0;
    end

    always_comb begin
        hit_oh  = lk_go ? first_one(hit_vec) : '0;
        hit_res = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_oh[w]) hit_res = hit_res | ov_res[w];
        end
    end

    flowc_recency #(
        .NWAYS (NWAYS),
        .IDX_W (IDX_W)
    ) u_recency (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .t0_en  (|ins_we),
        .t0_idx (ins_index),
        .t0_way (ins_we),
        .t1_en  (|hit_oh),
        .t1_idx (lk_index),
        .t1_way (hit_oh),
        .q_idx  (ins_index),
        .victim (victim)
    );

    flowc_ratio u_ratio (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .upd   (lk_go),
        .hit   (|hit_oh),
        .admit (admit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_class_q <= '0;
        end else begin
            rsp_valid_q <= lk_go;
            rsp_hit_q   <= |hit_oh;
            rsp_class_q <= hit_res;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_class = rsp_class_q;

    // R1: every accepted lookup is answered one cycle later
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !clr) |=> rsp_valid);

    // R1: a hit is only reported inside a response
    assert_hit_in_rsp_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R9: a lookup in a clear cycle gets no response
    assert_clear_no_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> !rsp_valid);

    // R3: an insert writes at most one way
    assert_one_write_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_we));

endmodule

// File: tb/flowc_cache_tb.sv
`timescale 1ns/1ps
module flowc_cache_tb;
    localparam int NW  = 4;
    localparam int IW  = 2;
    localparam int DEP = 1 << IW;
    localparam int IDW = 8;
    localparam int RW  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic lk_valid = 1'b0;
    logic [IDW-1:0] lk_flow = '0;
    logic [IW-1:0]  lk_index = '0;
    logic ins_valid = 1'b0;
    logic [IDW-1:0] ins_flow = '0;
    logic [IW-1:0]  ins_index = '0;
    logic [RW-1:0]  ins_class = '0;
    logic rsp_valid, rsp_hit;
    logic [RW-1:0] rsp_class;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flowc_cache #(.NWAYS(NW), .IDX_W(IW), .ID_W(IDW), .RES_W(RW)) u_dut (
        .clk(clk), .rst(rst), .clr(clr),
        .lk_valid(lk_valid), .lk_flow(lk_flow), .lk_index(lk_index),
        .ins_valid(ins_valid), .ins_flow(ins_flow), .ins_index(ins_index),
        .ins_class(ins_class),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_class(rsp_class)
    );

    // Reference state built from the requirements
    bit            m_v   [DEP][NW];
    bit [IDW-1:0]  m_id  [DEP][NW];
    bit [RW-1:0]   m_res [DEP][NW];
    bit [NW-1:0]   m_mru [DEP];
    int            m_h;
    bit [15:0]     m_lfsr;
    bit            e_valid, e_hit;
    bit [RW-1:0]   e_res;

    function automatic bit [NW-1:0] touch(bit [NW-1:0] b, int w);
        bit [NW-1:0] t;
        t = b | (NW'(1) << w);
        return (t == {NW{1'b1}}) ? (NW'(1) << w) : t;
    endfunction

    task automatic model_clear();
        for (int s = 0; s < DEP; s++) begin
            m_mru[s] = '0;
            for (int w = 0; w < NW; w++) m_v[s][w] = 0;
        end
        m_h = 0;
    endtask

    task automatic model_step(bit lv, bit [IDW-1:0] lid, int lix,
                              bit iv, bit [IDW-1:0] iid, int iix, bit [RW-1:0] ires, bit c);
        int sel;
        int hw;
        int d;
        e_valid = 0; e_hit = 0; e_res = '0;
        if (c) begin
            model_clear();
        end else begin
            if (iv) begin
                sel = -1;
                for (int w = NW - 1; w >= 0; w--) if (m_v[iix][w] && m_id[iix][w] == iid) sel = w;
                if (sel < 0) for (int w = NW - 1; w >= 0; w--) if (!m_v[iix][w]) sel = w;
                if (sel < 0 && int'(m_lfsr) < m_h)
                    for (int w = NW - 1; w >= 0; w--) if (!m_mru[iix][w]) sel = w;
                if (sel >= 0) begin
                    m_v[iix][sel] = 1; m_id[iix][sel] = iid; m_res[iix][sel] = ires;
                    m_mru[iix] = touch(m_mru[iix], sel);
                end
            end
            if (lv) begin
                e_valid = 1;
                hw = -1;
                for (int w = NW - 1; w >= 0; w--) if (m_v[lix][w] && m_id[lix][w] == lid) hw = w;
                if (hw >= 0) begin
                    e_hit = 1; e_res = m_res[lix][hw];
                    m_mru[lix] = touch(m_mru[lix], hw);
                end
                d = m_h - (m_h >> 4) - (m_h >> 5) + (m_h >> 7) + (e_hit ? 6554 : 0);
                m_h = (d > 65535) ? 65535 : d;
            end
        end
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    endtask

    task automatic cyc(string tag, bit lv, bit [IDW-1:0] lid, int lix,
                       bit iv, bit [IDW-1:0] iid, int iix, bit [RW-1:0] ires, bit c);
        lk_valid = lv; lk_flow = lid; lk_index = IW'(lix);
        ins_valid = iv; ins_flow = iid; ins_index = IW'(iix); ins_class = ires;
        clr = c;
        @(posedge clk);
        model_step(lv, lid, lix, iv, iid, iix, ires, c);
        @(negedge clk);
        lk_valid = 0; ins_valid = 0; clr = 0;
        checks++;
        if (rsp_valid !== e_valid || (e_valid && (rsp_hit !== e_hit || rsp_class !== e_res))) begin
            errors++;
            $display("FAIL %s: valid/hit/class act %0b/%0b/%0d exp %0b/%0b/%0d",
                     tag, rsp_valid, rsp_hit, rsp_class, e_valid, e_hit, e_res);
        end
    endtask

    task automatic expect_rsp(string tag, bit hit, bit [RW-1:0] res);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_class !== res) begin
            errors++;
            $display("FAIL %s: hit/class act %0b/%0d exp %0b/%0d", tag, rsp_hit, rsp_class, hit, res);
        end
    endtask

    task automatic look(string tag, bit [IDW-1:0] id, int ix);
        cyc(tag, 1, id, ix, 0, 0, 0, 0, 0);
    endtask

    task automatic ins(string tag, bit [IDW-1:0] id, int ix, bit [RW-1:0] r);
        cyc(tag, 0, 0, 0, 1, id, ix, r, 0);
    endtask

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_clear();
        m_lfsr = 16'hACE1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10: rsp_valid act %0b exp 0", rsp_valid);
        end
        look("R10", 8'd5, 0);
        expect_rsp("R10", 0, 0);

        // Fill set 1 while h is 0; a fifth flow must be dropped
        for (int i = 0; i < 4; i++) ins("R3", IDW'(10 + i), 1, RW'(1 + i));
        ins("R4", 8'd20, 1, 3'd6);
        look("R4", 8'd20, 1);
        expect_rsp("R4", 0, 0);
        for (int i = 0; i < 4; i++) begin
            look("R3", IDW'(10 + i), 1);
            expect_rsp("R3", 1, RW'(1 + i));
        end

        // Overwrite a resident flow's result
        ins("R2", 8'd11, 1, 3'd7);
        look("R2", 8'd11, 1);
        expect_rsp("R2", 1, 3'd7);
        look("R2", 8'd12, 1);
        expect_rsp("R2", 1, 3'd3);

        // Same-cycle insert and lookup at one index
        cyc("R8", 1, 8'd30, 2, 1, 8'd30, 2, 3'd5, 0);
        expect_rsp("R8", 1, 3'd5);
        cyc("R8", 1, 8'd31, 3, 1, 8'd32, 3, 3'd2, 0);
        expect_rsp("R8", 0, 0);

        // Raise h with hits, then force evictions into the full set
        for (int i = 0; i < 70; i++) look("R6", 8'd10, 1);
        for (int i = 0; i < 6; i++) begin
            ins("R5", IDW'(40 + i), 1, RW'(i));
            for (int j = 0; j < 4; j++) look("R5", IDW'(10 + j), 1);
            look("R5", IDW'(40 + i), 1);
        end

        // Clear in a cycle that also carries a lookup and an insert
        cyc("R9", 1, 8'd10, 1, 1, 8'd50, 0, 3'd1, 1);
        look("R9", 8'd10, 1);
        expect_rsp("R9", 0, 0);
        look("R9", 8'd50, 0);
        expect_rsp("R9", 0, 0);
        for (int i = 0; i < 4; i++) ins("R9", IDW'(60 + i), 0, RW'(i));
        ins("R9", 8'd70, 0, 3'd4);
        look("R9", 8'd70, 0);
        expect_rsp("R9", 0, 0);

        // Mixed traffic over every index with a small flow pool
        seed = 32'h1234567;
        for (int n = 0; n < 4000; n++) begin
            bit [31:0] r;
            seed = seed * 1103515245 + 12345;
            r = seed;
            cyc("R6/R7/R1", r[0] | r[1], IDW'(r[7:4] % 10), int'(r[9:8]),
                r[2], IDW'(r[13:10] % 10), int'(r[15:14]), RW'(r[18:16]),
                (r[30:21] == 10'd0));
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule